// File: doc/BRIEF.md
# Queue Pointer Controller

The block keeps a bank of hardware queue pointer pairs for a host that produces and consumes descriptors held elsewhere. Every queue owns a free-running 18-bit read pointer and a free-running 18-bit write pointer, which wrap modulo 2^18. Each queue also has a power-of-two size and sticky flags. A pointer never takes an absolute value from the host. It moves only when the host writes a small increment to the queue's add register. The host reads the pointers back through two status words. Those words also carry the flags, the occupancy state and the configured size.

The register side is a plain single-cycle bus. A request is accepted in the cycle `req_valid` is high, and no back-pressure exists. A read returns its data one cycle later with `rsp_valid`. The queue area begins at byte address 0x80000, and each queue owns a 0x800-byte window. A separate configuration port sets each queue's size as a base-2 logarithm. Per-queue full, empty and overflow levels are driven as plain status outputs.

Top module: `qpc_top`

## Requirements
- R1: After reset, every pointer reads 0 and every flag reads 0. Every queue reports empty, and each size logarithm equals DEF_SIZE_LOG (8). `rsp_valid` is low.
- R2: A write of a value from 0 to 63 to window offset 0x4 adds that value to the queue's write pointer, modulo 2^18.
- R3: A write of a value from 0 to 63 to window offset 0x0 adds that value to the queue's read pointer, modulo 2^18.
- R4: A read at window offset 0x8 returns read pointer in [17:0], error flag in [24], underflow flag in [25] and empty in [26]. A read at offset 0xC returns write pointer in [17:0], overflow flag in [24], full in [25] and size logarithm in [31:27]. Every read returns `rsp_valid` high with its data exactly one cycle after the request, and `rsp_valid` is low in every other cycle.
- R5: An add write whose 32-bit value exceeds 63 leaves the pointer unchanged and sets the queue's sticky error flag.
- R6: Occupancy is (write pointer − read pointer) mod 2^18. A write-pointer add that makes occupancy plus increment exceed the size sets the sticky overflow flag, which `q_ovf` also shows. The pointer still moves.
- R7: A read-pointer add whose increment exceeds the occupancy sets the sticky underflow flag. The pointer still moves.
- R8: `q_empty` is high when occupancy is 0. `q_full` is high when occupancy is at least the size. The two are never high together.
- R9: The queue index is bits [18:11] of (address − 0x80000), so higher address bits alias. Addresses below 0x80000 and index values of NUM_Q (6) or more are unmapped.
- R10: A `cfg_we` pulse sets the size logarithm of queue `cfg_qidx`. Values above 17 are stored as 17.
- R11: Reads of unmapped addresses or of window offsets other than 0x0, 0x4, 0x8 and 0xC return 0. Writes to any of these, and writes to the status offsets 0x8 and 0xC, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Byte address in target space |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| cfg_we | input | 1 | Size configuration strobe |
| cfg_qidx | input | 3 | Queue to configure |
| cfg_size_log2 | input | 5 | New size logarithm |
| q_full | output | 6 | Per-queue full level |
| q_empty | output | 6 | Per-queue empty level |
| q_ovf | output | 6 | Per-queue sticky overflow |

## Verification
On every cycle, the assertions check four things: the one-cycle read response timing, the stickiness of the overflow outputs, that full and empty are never high together, and the cleared state that follows reset. Only the bench scenarios can show that pointer arithmetic is correct. This covers modular wrap, the rejection of increments above 63 with the error flag, and overflow and underflow detection against a configured size. It also covers clamping of the size logarithm, address aliasing, and the silence of unmapped and status offsets on write. The bench checks these through reads of the status words that it compares with a reference model.

// File: rtl/qpc_pkg.sv
package qpc_pkg;
  localparam int WIN_SHIFT = 11;
  localparam int QSEL_W    = 8;
  localparam int ADD_LIMIT = 63;
  localparam int ADD_W     = 6;
  localparam int LOG_W     = 5;

  localparam int B_ERR   = 24;
  localparam int B_UDF   = 25;
  localparam int B_EMPTY = 26;
  localparam int B_OVF   = 24;
  localparam int B_FULL  = 25;
  localparam int B_LOG   = 27;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ADD_RD,
    SEL_ADD_WR,
    SEL_STAT_LO,
    SEL_STAT_HI
  } reg_sel_e;

  typedef struct packed {
    logic ovf;
    logic udf;
    logic err;
  } qflags_t;
endpackage

// File: rtl/qpc_decode.sv
module qpc_decode
  import qpc_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int NUM_Q  = 6,
  parameter logic [31:0] BASE = 32'h0008_0000,
  localparam int QW    = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
  localparam int OFF_W = WIN_SHIFT + QSEL_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [QW-1:0]     qidx,
  output reg_sel_e          sel
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);

  logic [OFF_W-1:0]     off;
  logic [QSEL_W-1:0]    qnum;
  logic                 in_region;
  logic                 q_ok;
  reg_sel_e             raw_sel;

  always_comb begin
    off       = OFF_W'(addr - BASE_A);
    qnum      = off[WIN_SHIFT +: QSEL_W];
    in_region = (addr >= BASE_A);
    q_ok      = ({1'b0, qnum} < (QSEL_W+1)'(NUM_Q));
    unique case (off[WIN_SHIFT-1:0])
      11'h000: raw_sel = SEL_ADD_RD;
      11'h004: raw_sel = SEL_ADD_WR;
      11'h008: raw_sel = SEL_STAT_LO;
      11'h00C: raw_sel = SEL_STAT_HI;
      default: raw_sel = SEL_NONE;
    endcase
    hit  = in_region && q_ok && (raw_sel != SEL_NONE);
    sel  = hit ? raw_sel : SEL_NONE;
    qidx = qnum[QW-1:0];
  end
endmodule

// File: rtl/qpc_queue.sv
module qpc_queue
  import qpc_pkg::*;
#(
  parameter int PTR_W   = 18,
  parameter int DEF_LOG = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              add_rd,
  input  logic              add_wr,
  input  logic              add_bad,
  input  logic [ADD_W-1:0]  add_val,
  input  logic              cfg_we,
  input  logic [LOG_W-1:0]  cfg_log,
  output logic [PTR_W-1:0]  rptr,
  output logic [PTR_W-1:0]  wptr,
  output logic [LOG_W-1:0]  size_log,
  output qflags_t           flags,
  output logic              full,
  output logic              empty
);
  localparam logic [LOG_W-1:0] LOG_MAX = LOG_W'(PTR_W - 1);

  logic [PTR_W-1:0] occ;
  logic [PTR_W:0]   size_v;
  logic [PTR_W:0]   occ_after;
  logic [PTR_W:0]   inc_ext;
  logic             good_rd, good_wr;
  logic             will_ovf, will_udf;
  logic [LOG_W-1:0] log_clamped;

  always_comb begin
    occ         = wptr - rptr;
    size_v      = (PTR_W+1)'(1) << size_log;
    inc_ext     = (PTR_W+1)'(add_val);
    occ_after   = {1'b0, occ} + inc_ext;
    good_rd     = add_rd && !add_bad;
    good_wr     = add_wr && !add_bad;
    will_ovf    = good_wr && (occ_after > size_v);
    will_udf    = good_rd && (inc_ext > {1'b0, occ});
    log_clamped = (cfg_log > LOG_MAX) ? LOG_MAX : cfg_log;
    full        = ({1'b0, occ} >= size_v);
    empty       = (occ == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr     <= '0;
      wptr     <= '0;
      size_log <= LOG_W'(DEF_LOG);
      flags    <= '0;
    end else begin
      if (good_rd) rptr <= rptr + PTR_W'(add_val);
      if (good_wr) wptr <= wptr + PTR_W'(add_val);
      if (cfg_we)  size_log <= log_clamped;
      if ((add_rd || add_wr) && add_bad) flags.err <= 1'b1;
      if (will_ovf) flags.ovf <= 1'b1;
      if (will_udf) flags.udf <= 1'b1;
    end
  end
endmodule

// File: rtl/qpc_rdmux.sv
module qpc_rdmux
  import qpc_pkg::*;
#(
  parameter int NUM_Q = 6,
  localparam int QW   = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rd_go,
  input  logic                   rd_hit,
  input  reg_sel_e               sel,
  input  logic [QW-1:0]          qidx,
  input  logic [NUM_Q-1:0][31:0] lo_words,
  input  logic [NUM_Q-1:0][31:0] hi_words,
  output logic                   rsp_valid,
  output logic [31:0]            rsp_rdata
);
  logic [31:0] word;

  always_comb begin
    word = '0;
    if (rd_hit) begin
      if (sel == SEL_STAT_LO)      word = lo_words[qidx];
      else if (sel == SEL_STAT_HI) word = hi_words[qidx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_go;
      if (rd_go) rsp_rdata <= word;
    end
  end
endmodule

// File: rtl/qpc_top.sv
module qpc_top
  import qpc_pkg::*;
#(
  parameter int NUM_Q    = 6,
  parameter int PTR_W    = 18,
  parameter int ADDR_W   = 21,
  parameter int DEF_SIZE_LOG = 8,
  parameter logic [31:0] BASE = 32'h0008_0000,
  localparam int QW      = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  input  logic              cfg_we,
  input  logic [QW-1:0]     cfg_qidx,
  input  logic [LOG_W-1:0]  cfg_size_log2,
  output logic [NUM_Q-1:0]  q_full,
  output logic [NUM_Q-1:0]  q_empty,
  output logic [NUM_Q-1:0]  q_ovf
);
  logic          hit;
  logic [QW-1:0] qidx;
  reg_sel_e      sel;
  logic          wr_go, rd_go, add_bad;
  logic [NUM_Q-1:0][31:0] lo_words;
  logic [NUM_Q-1:0][31:0] hi_words;

  qpc_decode #(.ADDR_W(ADDR_W), .NUM_Q(NUM_Q), .BASE(BASE)) u_dec (
    .addr(req_addr), .hit(hit), .qidx(qidx), .sel(sel)
  );

  always_comb begin
    wr_go   = req_valid && req_write && hit;
    rd_go   = req_valid && !req_write;
    add_bad = (req_wdata > 32'(ADD_LIMIT));
  end

  for (genvar g = 0; g < NUM_Q; g++) begin : g_q
    logic [PTR_W-1:0] rptr, wptr;
    logic [LOG_W-1:0] size_log;
    qflags_t          flags;
    logic             this_q;

    assign this_q = wr_go && (qidx == QW'(g));

    qpc_queue #(.PTR_W(PTR_W), .DEF_LOG(DEF_SIZE_LOG)) u_q (
      .clk(clk), .rst_n(rst_n),
      .add_rd(this_q && (sel == SEL_ADD_RD)),
      .add_wr(this_q && (sel == SEL_ADD_WR)),
      .add_bad(add_bad),
      .add_val(req_wdata[ADD_W-1:0]),
      .cfg_we(cfg_we && (cfg_qidx == QW'(g))),
      .cfg_log(cfg_size_log2),
      .rptr(rptr), .wptr(wptr), .size_log(size_log), .flags(flags),
      .full(q_full[g]), .empty(q_empty[g])
    );

    always_comb begin
      lo_words[g] = '0;
      lo_words[g][PTR_W-1:0] = rptr;
      lo_words[g][B_ERR]     = flags.err;
      lo_words[g][B_UDF]     = flags.udf;
      lo_words[g][B_EMPTY]   = q_empty[g];
      hi_words[g] = '0;
      hi_words[g][PTR_W-1:0] = wptr;
      hi_words[g][B_OVF]     = flags.ovf;
      hi_words[g][B_FULL]    = q_full[g];
      hi_words[g][B_LOG +: LOG_W] = size_log;
    end

    assign q_ovf[g] = flags.ovf;
  end

  qpc_rdmux #(.NUM_Q(NUM_Q)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_go(rd_go), .rd_hit(hit), .sel(sel),
    .qidx(qidx), .lo_words(lo_words), .hi_words(hi_words),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );
endmodule

// File: rtl/qpc_checker.sv
module qpc_checker #(
  parameter int NUM_Q = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic             rsp_valid,
  input logic [NUM_Q-1:0] q_full,
  input logic [NUM_Q-1:0] q_empty,
  input logic [NUM_Q-1:0] q_ovf
);
  assert_rsp_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  assert_rsp_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (q_ovf != '0) |=> ((q_ovf & $past(q_ovf)) == $past(q_ovf)));

  assert_full_empty_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (q_full & q_empty) == '0);

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (q_ovf == '0 && q_empty == '1 && !rsp_valid));
endmodule

bind qpc_top qpc_checker #(.NUM_Q(NUM_Q)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .rsp_valid(rsp_valid), .q_full(q_full), .q_empty(q_empty), .q_ovf(q_ovf)
);

// File: tb/test_qpc_top.sv
module test_qpc_top;
  localparam int CLK_PERIOD = 10;
  localparam int NQ   = 6;
  localparam int BASE = 32'h80000;
  localparam int MASK = 32'h3FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [20:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_qidx = '0;
  logic [4:0]  cfg_size_log2 = '0;
  logic [NQ-1:0] q_full, q_empty, q_ovf;

  int total = 0, bad = 0;
  int unsigned rp[NQ], wp[NQ], lg[NQ];
  bit ovf[NQ], udf[NQ], err[NQ];

  always #(CLK_PERIOD/2) clk = ~clk;

  qpc_top i_qpc_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .cfg_we(cfg_we), .cfg_qidx(cfg_qidx),
    .cfg_size_log2(cfg_size_log2), .q_full(q_full), .q_empty(q_empty),
    .q_ovf(q_ovf)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int unsigned occ_of(int q);
    return (wp[q] - rp[q]) & MASK;
  endfunction

  function automatic bit map(int unsigned a, output int q, output int w);
    int unsigned off;
    if (a < BASE) return 0;
    off = a - BASE;
    q = (off >> 11) & 255;
    w = off & 'h7FF;
    return q < NQ;
  endfunction

  function automatic void mdl_write(int unsigned a, int unsigned d);
    int q, w;
    int unsigned o;
    if (!map(a, q, w)) return;
    if (w != 0 && w != 4) return;
    if (d > 63) begin err[q] = 1; return; end
    o = occ_of(q);
    if (w == 4) begin
      if (o + d > (1 << lg[q])) ovf[q] = 1;
      wp[q] = (wp[q] + d) & MASK;
    end else begin
      if (d > o) udf[q] = 1;
      rp[q] = (rp[q] + d) & MASK;
    end
  endfunction

  function automatic logic [31:0] mdl_read(int unsigned a);
    int q, w;
    int unsigned o;
    if (!map(a, q, w)) return 0;
    o = occ_of(q);
    if (w == 8)
      return rp[q] | (32'(err[q]) << 24) | (32'(udf[q]) << 25) | (32'(o == 0) << 26);
    if (w == 'hC)
      return wp[q] | (32'(ovf[q]) << 24) | (32'(o >= (1 << lg[q])) << 25) | (lg[q] << 27);
    return 0;
  endfunction

  function automatic logic [NQ-1:0] mdl_full();
    for (int q = 0; q < NQ; q++) mdl_full[q] = occ_of(q) >= (1 << lg[q]);
  endfunction

  function automatic logic [NQ-1:0] mdl_empty();
    for (int q = 0; q < NQ; q++) mdl_empty[q] = occ_of(q) == 0;
  endfunction

  task automatic wr(int unsigned a, int unsigned d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 21'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    mdl_write(a, d);
  endtask

  task automatic rd(string req, int unsigned a);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 21'(a);
    @(negedge clk);
    req_valid = 0;
    check({req, " rsp_valid"}, 32'(rsp_valid), 32'd1);
    check(req, rsp_rdata, mdl_read(a));
  endtask

  task automatic cfg(int q, int l);
    @(negedge clk);
    cfg_we = 1; cfg_qidx = 3'(q); cfg_size_log2 = 5'(l);
    @(negedge clk);
    cfg_we = 0;
    lg[q] = (l > 17) ? 17 : l;
  endtask

  function automatic int unsigned qa(int q, int w);
    return BASE + q * 'h800 + w;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int q = 0; q < NQ; q++) begin
      rp[q] = 0; wp[q] = 0; lg[q] = 8; ovf[q] = 0; udf[q] = 0; err[q] = 0;
    end
    repeat (3) @(negedge clk);
    check("R1 rsp_valid in reset", 32'(rsp_valid), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 empty", 32'(q_empty), 32'h3F);
    check("R1 ovf", 32'(q_ovf), 0);
    for (int q = 0; q < NQ; q++) begin
      rd("R1 lo", qa(q, 8));
      rd("R1 hi", qa(q, 'hC));
    end

    wr(qa(0, 4), 5);   rd("R2 wptr add", qa(0, 'hC));
    wr(qa(0, 0), 3);   rd("R3 rptr add", qa(0, 8));
    wr(qa(0, 4), 64);  rd("R5 big add ignored", qa(0, 'hC));
    rd("R5 err flag", qa(0, 8));
    check("R5 err bit", mdl_read(qa(0, 8)) >> 24 & 1, 1);

    cfg(2, 2);
    wr(qa(2, 4), 4);   check("R8 full", 32'(q_full[2]), 1);
    wr(qa(2, 4), 1);   rd("R6 ovf word", qa(2, 'hC));
    check("R6 q_ovf", 32'(q_ovf[2]), 1);
    check("R8 not empty", 32'(q_empty[2]), 0);

    wr(qa(3, 0), 1);   rd("R7 udf word", qa(3, 8));
    cfg(4, 31);        rd("R10 clamp", qa(4, 'hC));
    check("R10 lg field", rsp_rdata >> 27, 17);

    rd("R11 off 0x10", qa(1, 'h10));
    rd("R9 q6 unmapped", qa(6, 'hC));
    wr(qa(1, 8), 7);   rd("R11 write to status", qa(1, 8));
    wr(BASE - 'h800 + 4, 9); rd("R9 below base", qa(1, 'hC));
    wr(qa(1, 4) + 256 * 'h800, 9); rd("R9 alias write", qa(1, 'hC));
    check("R9 alias wptr", rsp_rdata & MASK, 9);

    cfg(5, 17);
    for (int i = 0; i < 4161; i++) wr(qa(5, 4), 63);
    wr(qa(5, 4), 2);   rd("R2 wrap", qa(5, 'hC));
    check("R2 wrapped value", rsp_rdata & MASK, 1);

    for (int i = 0; i < 600; i++) begin
      int q = int'($urandom_range(7));
      int k = int'($urandom_range(4));
      int unsigned w = (k == 4) ? 'h10 : k * 4;
      int unsigned d = ($urandom_range(9) == 0) ? $urandom : $urandom_range(63);
      if ($urandom_range(9) == 0) cfg(int'($urandom_range(5)), int'($urandom_range(20)));
      else if ($urandom_range(9) < 6) wr(qa(q, int'(w)), d);
      else rd("R4 random read", qa(q, int'(w)));
      check("R8 full vec", 32'(q_full), 32'(mdl_full()));
      check("R8 empty vec", 32'(q_empty), 32'(mdl_empty()));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule